// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block decides when a microcontroller core drops into a low-power state, which clock domains stay alive while it sleeps, and when it comes back. Software programs a byte-wide control register that holds a sleep-enable flag and a three-bit mode selector. The CPU then issues a one-cycle sleep strobe. If the flag is set and the mode code is defined, the controller latches the mode and removes the clock enables of the domains that this mode stops.

Five clock-enable outputs cover the CPU, flash, general I/O peripherals, ADC and asynchronous timer domains. Each mode has its own set of wake sources. When a qualifying request arrives, every domain is enabled again and the CPU receives a one-cycle wake pulse. When the controller enters idle mode while the ADC is enabled, it fires a one-cycle conversion-start pulse.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the register reads 8'h00, all five clock enables are 1, and `wake_pulse` and `adc_start` are 0.
- R2: On a write, bit 0 stores the sleep-enable flag and bits 3..1 store the mode code. Bits 7..4 always read 0, and writing to them has no effect.
- R3: A sleep strobe while the sleep-enable flag is 0 is ignored, and all clock enables stay 1.
- R4: A strobe that selects a reserved mode code (3'b100, 3'b101 or 3'b111) is ignored, and the controller stays in run with all enables at 1.
- R5: While asleep, the enables {async, adc, io, flash, cpu} are:
  - idle (3'b000): 5'b11100
  - ADC noise reduction (3'b001): 5'b11000
  - power-save (3'b011): 5'b10000
  - power-down (3'b010): 5'b00000
  - standby (3'b110): 5'b00000
- R6: Wake sources depend on the mode.
  - `irq_ext` wakes every mode.
  - `irq_async` wakes idle, ADC noise reduction and power-save.
  - `irq_sync` wakes idle and ADC noise reduction.
  - A request that does not qualify leaves the controller asleep.
- R7: On the clock edge that wakes the controller, all enables return to 1 and `wake_pulse` is high for exactly one cycle. Sleep strobes that arrive while asleep are ignored.
- R8: Entering idle with `adc_on` high produces exactly one `adc_start` cycle, in the first sleeping cycle. No pulse is produced for idle with `adc_on` low, or for any other mode.
- R9: Hardware never clears the sleep-enable flag, so it still reads 1 after a wake. A strobe in the same cycle as a register write uses the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| sleep_req | input | 1 | One-cycle sleep strobe from the CPU |
| adc_on | input | 1 | ADC enabled |
| irq_ext | input | 1 | External or asynchronous-pin wake request |
| irq_async | input | 1 | Asynchronous timer interrupt |
| irq_sync | input | 1 | Synchronous peripheral interrupt |
| ce_cpu | output | 1 | CPU clock enable |
| ce_flash | output | 1 | Flash clock enable |
| ce_io | output | 1 | I/O peripheral clock enable |
| ce_adc | output | 1 | ADC clock enable |
| ce_async | output | 1 | Asynchronous timer clock enable |
| wake_pulse | output | 1 | One-cycle wake indication to the CPU |
| adc_start | output | 1 | One-cycle ADC conversion start |

## Verification
The assertions check, on every cycle, the properties that do not depend on the mode:
- a strobe with the flag clear, or with a reserved code, never leads to sleep;
- the CPU enable is low whenever the controller sleeps;
- a wake pulse always coincides with all enables high;
- `adc_start` never lasts two cycles;
- the deep modes ignore everything except `irq_ext`.

The directed scenarios cover what needs a chosen stimulus:
- the exact enable pattern of each mode;
- which wake sources each mode rejects and which it accepts;
- that the flag persists after wake;
- the ordering when a write and a strobe land on the same edge.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
  localparam int CFG_W  = 8;
  localparam int MODE_W = 3;
  localparam int DOM_N  = 5;

  localparam int D_CPU   = 0;
  localparam int D_FLASH = 1;
  localparam int D_IO    = 2;
  localparam int D_ADC   = 3;
  localparam int D_ASYNC = 4;

  localparam logic [MODE_W-1:0] M_IDLE  = 3'b000;
  localparam logic [MODE_W-1:0] M_ADCNR = 3'b001;
  localparam logic [MODE_W-1:0] M_PDOWN = 3'b010;
  localparam logic [MODE_W-1:0] M_PSAVE = 3'b011;
  localparam logic [MODE_W-1:0] M_STBY  = 3'b110;

  function automatic logic mode_valid(input logic [MODE_W-1:0] m);
    return (m == M_IDLE) || (m == M_ADCNR) || (m == M_PDOWN) ||
           (m == M_PSAVE) || (m == M_STBY);
  endfunction

  // Domains left running while asleep in mode m
  function automatic logic [DOM_N-1:0] dom_mask(input logic [MODE_W-1:0] m);
    logic [DOM_N-1:0] r;
    r = '0;
    case (m)
      M_IDLE:  begin r[D_IO] = 1'b1; r[D_ADC] = 1'b1; r[D_ASYNC] = 1'b1; end
      M_ADCNR: begin r[D_ADC] = 1'b1; r[D_ASYNC] = 1'b1; end
      M_PSAVE: r[D_ASYNC] = 1'b1;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic wake_ok(input logic [MODE_W-1:0] m, input logic ext,
                                   input logic asy, input logic syn);
    logic keeps_async, keeps_sync;
    keeps_async = dom_mask(m)[D_ASYNC];
    keeps_sync  = dom_mask(m)[D_ADC];
    return ext || (asy && keeps_async) || (syn && keeps_sync);
  endfunction
endpackage

// File: rtl/pwr_sleep_cfg.sv
module pwr_sleep_cfg
  import pwr_sleep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W:0]   wdata,
  output logic              slp_en,
  output logic [MODE_W-1:0] mode_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_en   <= 1'b0;
      mode_sel <= '0;
    end else if (we) begin
      slp_en   <= wdata[0];
      mode_sel <= wdata[MODE_W:1];
    end
  end
endmodule

// File: rtl/pwr_sleep_fsm.sv
module pwr_sleep_fsm
  import pwr_sleep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slp_en,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              sleep_req,
  input  logic              adc_on,
  input  logic              irq_ext,
  input  logic              irq_async,
  input  logic              irq_sync,
  output logic              asleep,
  output logic [MODE_W-1:0] cur_mode,
  output logic              wake_pulse,
  output logic              adc_start
);
  logic enter_evt, wake_evt;

  assign enter_evt = !asleep && sleep_req && slp_en && mode_valid(mode_sel);
  assign wake_evt  = asleep && wake_ok(cur_mode, irq_ext, irq_async, irq_sync);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep     <= 1'b0;
      cur_mode   <= M_IDLE;
      wake_pulse <= 1'b0;
      adc_start  <= 1'b0;
    end else begin
      wake_pulse <= wake_evt;
      adc_start  <= enter_evt && (mode_sel == M_IDLE) && adc_on;
      if (enter_evt) begin
        asleep   <= 1'b1;
        cur_mode <= mode_sel;
      end else if (wake_evt) begin
        asleep <= 1'b0;
      end
    end
  end

  // R3 / R4: disabled or reserved strobes never put the core to sleep
  a_r3_no_entry_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && sleep_req && !slp_en) |=> !asleep);
  a_r4_reserved_code_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && sleep_req && !mode_valid(mode_sel)) |=> !asleep);
  // R6: deep modes only listen to the external request
  a_r6_deep_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && (cur_mode == M_PDOWN || cur_mode == M_STBY) && !irq_ext) |=> asleep);
  // R8: start pulse lasts one cycle
  a_r8_adc_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             sleep_req,
  input  logic             adc_on,
  input  logic             irq_ext,
  input  logic             irq_async,
  input  logic             irq_sync,
  output logic             ce_cpu,
  output logic             ce_flash,
  output logic             ce_io,
  output logic             ce_adc,
  output logic             ce_async,
  output logic             wake_pulse,
  output logic             adc_start
);
  localparam int RSV_W = CFG_W - MODE_W - 1;

  logic              slp_en;
  logic [MODE_W-1:0] mode_sel;
  logic              asleep;
  logic [MODE_W-1:0] cur_mode;
  logic [DOM_N-1:0]  dom_on;
  logic [DOM_N-1:0]  sleep_mask;

  pwr_sleep_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata[MODE_W:0]),
    .slp_en   (slp_en),
    .mode_sel (mode_sel)
  );

  pwr_sleep_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .slp_en     (slp_en),
    .mode_sel   (mode_sel),
    .sleep_req  (sleep_req),
    .adc_on     (adc_on),
    .irq_ext    (irq_ext),
    .irq_async  (irq_async),
    .irq_sync   (irq_sync),
    .asleep     (asleep),
    .cur_mode   (cur_mode),
    .wake_pulse (wake_pulse),
    .adc_start  (adc_start)
  );

  assign cfg_rdata  = {{RSV_W{1'b0}}, mode_sel, slp_en};
  assign sleep_mask = dom_mask(cur_mode);

  for (genvar d = 0; d < DOM_N; d++) begin : g_dom
    assign dom_on[d] = !asleep || sleep_mask[d];
  end

  assign ce_cpu   = dom_on[D_CPU];
  assign ce_flash = dom_on[D_FLASH];
  assign ce_io    = dom_on[D_IO];
  assign ce_adc   = dom_on[D_ADC];
  assign ce_async = dom_on[D_ASYNC];

  // R2: upper bits stay zero after any write
  a_r2_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (|cfg_wdata[CFG_W-1:MODE_W+1])) |=> (cfg_rdata[CFG_W-1:MODE_W+1] == '0));
  // R5: CPU is never clocked while asleep
  a_r5_cpu_off_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !ce_cpu);
  // R7: wake pulse coincides with every domain enabled
  a_r7_wake_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (ce_cpu && ce_flash && ce_io && ce_adc && ce_async));
endmodule

// File: tb/pwr_sleep_ctrl_tb.sv
module pwr_sleep_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       sleep_req = 1'b0, adc_on = 1'b0;
  logic       irq_ext = 1'b0, irq_async = 1'b0, irq_sync = 1'b0;
  logic       ce_cpu, ce_flash, ce_io, ce_adc, ce_async, wake_pulse, adc_start;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pwr_sleep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sleep_req(sleep_req), .adc_on(adc_on), .irq_ext(irq_ext), .irq_async(irq_async),
    .irq_sync(irq_sync), .ce_cpu(ce_cpu), .ce_flash(ce_flash), .ce_io(ce_io),
    .ce_adc(ce_adc), .ce_async(ce_async), .wake_pulse(wake_pulse), .adc_start(adc_start)
  );

  function automatic logic [4:0] ce_vec();
    return {ce_async, ce_adc, ce_io, ce_flash, ce_cpu};
  endfunction

  // Expected enables while asleep, {async, adc, io, flash, cpu}
  function automatic logic [4:0] exp_sleep(input logic [2:0] m);
    case (m)
      3'b000:  return 5'b11100;
      3'b001:  return 5'b11000;
      3'b011:  return 5'b10000;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  // wake vector is {ext, async, sync}
  task automatic irq(input logic [2:0] v);
    @(negedge clk); {irq_ext, irq_async, irq_sync} = v;
    @(negedge clk); {irq_ext, irq_async, irq_sync} = 3'b000;
  endtask

  task automatic t_reset();
    check("R1 rdata", cfg_rdata, 8'h00);
    check("R1 enables", {3'b0, ce_vec()}, 8'h1f);
    check("R1 pulses", {6'b0, wake_pulse, adc_start}, 8'h00);
  endtask

  task automatic t_reg();
    wr(8'hff); check("R2 reserved bits read zero", cfg_rdata, 8'h0f);
    wr(8'hf0); check("R2 reserved write ignored", cfg_rdata, 8'h00);
    wr(8'h0d); check("R2 field placement", cfg_rdata, 8'h0d);
  endtask

  task automatic t_no_enable();
    wr({4'h0, 3'b010, 1'b0});
    strobe();
    check("R3 strobe ignored without enable", {3'b0, ce_vec()}, 8'h1f);
  endtask

  task automatic t_reserved();
    for (int k = 0; k < 3; k++) begin
      logic [2:0] m;
      m = (k == 0) ? 3'b100 : (k == 1) ? 3'b101 : 3'b111;
      wr({4'h0, m, 1'b1});
      strobe();
      check("R4 reserved code stays in run", {3'b0, ce_vec()}, 8'h1f);
    end
  endtask

  task automatic t_mode(input logic [2:0] m, input logic [2:0] bad, input logic [2:0] good);
    wr({4'h0, m, 1'b1});
    strobe();
    check("R5 sleep enables", {3'b0, ce_vec()}, {3'b0, exp_sleep(m)});
    if (bad != 3'b000) begin
      irq(bad);
      check("R6 non-qualifying wake ignored", {3'b0, ce_vec()}, {3'b0, exp_sleep(m)});
    end
    irq(good);
    check("R6 R7 wake enables", {3'b0, ce_vec()}, 8'h1f);
    check("R7 wake pulse high", {7'b0, wake_pulse}, 8'h01);
    @(negedge clk);
    check("R7 wake pulse one cycle", {7'b0, wake_pulse}, 8'h00);
    check("R9 enable flag kept", cfg_rdata, {4'h0, m, 1'b1});
  endtask

  task automatic t_adc();
    adc_on = 1'b1;
    wr(8'h01);
    strobe();
    check("R8 adc start on idle entry", {7'b0, adc_start}, 8'h01);
    @(negedge clk);
    check("R8 adc start one cycle", {7'b0, adc_start}, 8'h00);
    irq(3'b100);
    adc_on = 1'b0;
    strobe();
    check("R8 no start with adc off", {7'b0, adc_start}, 8'h00);
    irq(3'b100);
    adc_on = 1'b1;
    wr({4'h0, 3'b001, 1'b1});
    strobe();
    check("R8 no start in other mode", {7'b0, adc_start}, 8'h00);
    irq(3'b100);
    adc_on = 1'b0;
  endtask

  task automatic t_strobe_asleep();
    wr({4'h0, 3'b010, 1'b1});
    strobe();
    strobe();
    check("R7 strobe while asleep ignored", {3'b0, ce_vec()}, 8'h00);
    check("R7 no wake from strobe", {7'b0, wake_pulse}, 8'h00);
    irq(3'b100);
  endtask

  task automatic t_same_cycle();
    wr(8'h00);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = {4'h0, 3'b010, 1'b1}; sleep_req = 1'b1;
    @(negedge clk); cfg_we = 1'b0; sleep_req = 1'b0;
    check("R9 strobe uses old register", {3'b0, ce_vec()}, 8'h1f);
    strobe();
    check("R9 later strobe uses new value", {3'b0, ce_vec()}, 8'h00);
    irq(3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg();
    t_no_enable();
    t_reserved();
    t_mode(3'b000, 3'b000, 3'b001);
    t_mode(3'b000, 3'b000, 3'b100);
    t_mode(3'b001, 3'b000, 3'b010);
    t_mode(3'b011, 3'b001, 3'b010);
    t_mode(3'b010, 3'b011, 3'b100);
    t_mode(3'b110, 3'b011, 3'b100);
    t_adc();
    t_strobe_asleep();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule